// File: doc/BRIEF.md
# Receive Traffic Burst Interrupt Monitor

This block watches the receive side of a network port and tells a power manager when traffic has jumped. The incoming byte strobe is added up over back-to-back sampling windows of a programmable number of clock cycles. Each window's total is graded at its closing cycle against a high and a low level. A high window raises an interrupt straight away. A run of mid-level windows raises one once a programmed number of them has been seen.

Every interrupt is a single-cycle pulse. It opens a hold-off period of programmable length, during which no further pulse can be raised. Mid-level windows that close during hold-off still advance the mid-window tally, so the block does not lose track of a slow build-up. At a 250 MHz clock, typical settings are a window of 50,000 cycles (200 us) and a hold-off of 5,000,000 cycles (20 ms). All settings come in as static configuration inputs.

Top module: `burst_irq_monitor`

## Requirements
- R1: A window closes on every cycle in which the window cycle count reaches the effective length, which is `cfg_window_cycles`, or 2 when that value is below 2. The byte count presented on the closing cycle belongs to the next window. Bytes are added only in cycles with `rx_valid` high. The pulse for a window comes in the cycle after its closing cycle.
- R2: A window whose total is greater than or equal to `cfg_hi_level` and that closes outside hold-off raises `irq` and clears the mid-window tally.
- R3: A window whose total is below `cfg_hi_level` but greater than or equal to `cfg_lo_level` increments the mid-window tally. When the tally reaches `cfg_mid_needed` (0 counts as 1), the tally clears, and if the window closes outside hold-off `irq` is raised.
- R4: A window whose total is below both levels raises no pulse and leaves the tally unchanged.
- R5: `irq` is high for exactly one cycle per event and is never high outside the cycle after a window close.
- R6: If `irq` is high in cycle t, then windows closing in cycles t to t+`cfg_holdoff_cycles`-1 cannot raise `irq`, so the next pulse comes no earlier than cycle t+`cfg_holdoff_cycles`+1. A high window in hold-off leaves the tally unchanged.
- R7: Mid-level windows that close during hold-off still count. If such a window brings the tally to its target, the tally clears and no pulse is raised.
- R8: While `rst_n` is low, `irq` is low and every counter is cleared. After release, the first window closes in cycle length-1, counting the first cycle after release as cycle 0.
- R9: The window total saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 1 | Byte-received strobe |
| rx_bytes | input | BYTE_W | Bytes received in this cycle |
| cfg_hi_level | input | ACC_W | Window total that fires at once |
| cfg_lo_level | input | ACC_W | Window total that counts as mid-level |
| cfg_mid_needed | input | MCNT_W | Number of mid-level windows that fires |
| cfg_window_cycles | input | WIN_W | Window length in cycles |
| cfg_holdoff_cycles | input | HOLD_W | Hold-off length in cycles |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The assertions assume that every configuration input holds still while `rst_n` is high. The hold-off and grading rules are checked against the configuration values, so a change in the middle of a run would make a correct design appear to fail. The bench therefore changes settings only while reset is held. The stimulus also drives a non-zero byte count in cycles with the strobe low, so that ignored bytes show up in the window totals if the strobe is not honoured.

// File: rtl/bim_pkg.sv
package bim_pkg;
  typedef enum logic [1:0] {
    WIN_LOW  = 2'd0,
    WIN_MID  = 2'd1,
    WIN_HIGH = 2'd2
  } win_class_e;
endpackage

// File: rtl/bim_window_timer.sv
module bim_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] cfg_len,
  output logic             win_end
);
  localparam logic [WIN_W-1:0] MIN_LEN = WIN_W'(2);
  localparam logic [WIN_W-1:0] ONE     = WIN_W'(1);

  logic [WIN_W-1:0] cnt_q, cnt_d, eff_len;

  // Lengths below two are raised to two (R1)
  assign eff_len = (cfg_len < MIN_LEN) ? MIN_LEN : cfg_len;
  assign win_end = (cnt_q >= eff_len - ONE);

  always_comb begin
    cnt_d = win_end ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bim_byte_accum.sv
module bim_byte_accum #(
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_bytes,
  input  logic              win_end,
  output logic [ACC_W-1:0]  win_total
);
  localparam int PAD_W = ACC_W - BYTE_W;

  logic [ACC_W-1:0] acc_q, acc_d, add_w;
  logic [ACC_W:0]   sum_w;

  assign add_w     = rx_valid ? {{PAD_W{1'b0}}, rx_bytes} : '0;
  assign sum_w     = {1'b0, acc_q} + {1'b0, add_w};
  assign win_total = acc_q;

  always_comb begin
    if (win_end) begin
      // the closing cycle's bytes open the next window (R1)
      acc_d = add_w;
    end else if (sum_w[ACC_W]) begin
      // saturate on overflow (R9)
      acc_d = '1;
    end else begin
      acc_d = sum_w[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/bim_classify.sv
module bim_classify
  import bim_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic [ACC_W-1:0] win_total,
  input  logic [ACC_W-1:0] cfg_hi_level,
  input  logic [ACC_W-1:0] cfg_lo_level,
  output win_class_e       win_class
);
  always_comb begin
    if (win_total >= cfg_hi_level) begin
      win_class = WIN_HIGH;
    end else if (win_total >= cfg_lo_level) begin
      win_class = WIN_MID;
    end else begin
      win_class = WIN_LOW;
    end
  end
endmodule

// File: rtl/bim_trigger.sv
module bim_trigger
  import bim_pkg::*;
#(
  parameter int MCNT_W = 4,
  parameter int HOLD_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_end,
  input  win_class_e        win_class,
  input  logic [MCNT_W-1:0] cfg_mid_needed,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  output logic              irq
);
  logic [MCNT_W-1:0] mid_q, mid_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              irq_q, fire;
  logic              hold_act, mid_en, hold_en;
  logic [MCNT_W:0]   mid_inc, mid_need;

  assign hold_act = (hold_q != '0);
  assign mid_inc  = {1'b0, mid_q} + {{MCNT_W{1'b0}}, 1'b1};
  assign mid_need = (cfg_mid_needed == '0) ? {{MCNT_W{1'b0}}, 1'b1}
                                           : {1'b0, cfg_mid_needed};

  always_comb begin
    fire  = 1'b0;
    mid_d = mid_q;
    if (win_end) begin
      unique case (win_class)
        WIN_HIGH: begin
          if (!hold_act) fire = 1'b1;
        end
        WIN_MID: begin
          if (mid_inc >= mid_need) begin
            mid_d = '0;
            fire  = !hold_act;
          end else begin
            mid_d = mid_inc[MCNT_W-1:0];
          end
        end
        default: begin
        end
      endcase
    end
    if (fire) mid_d = '0;
  end

  always_comb begin
    if (fire) begin
      hold_d = cfg_holdoff;
    end else if (hold_act) begin
      hold_d = hold_q - HOLD_W'(1);
    end else begin
      hold_d = '0;
    end
  end

  assign mid_en  = win_end;
  assign hold_en = fire || hold_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= '0;
      hold_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mid_en)  mid_q  <= mid_d;
      if (hold_en) hold_q <= hold_d;
      irq_q <= fire;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/burst_irq_monitor.sv
module burst_irq_monitor
  import bim_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 24,
  parameter int MCNT_W = 4,
  parameter int WIN_W  = 16,
  parameter int HOLD_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_bytes,
  input  logic [ACC_W-1:0]  cfg_hi_level,
  input  logic [ACC_W-1:0]  cfg_lo_level,
  input  logic [MCNT_W-1:0] cfg_mid_needed,
  input  logic [WIN_W-1:0]  cfg_window_cycles,
  input  logic [HOLD_W-1:0] cfg_holdoff_cycles,
  output logic              irq
);
  logic             win_end;
  logic [ACC_W-1:0] win_total;
  win_class_e       win_class;

  bim_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_len (cfg_window_cycles),
    .win_end (win_end)
  );

  bim_byte_accum #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_bytes  (rx_bytes),
    .win_end   (win_end),
    .win_total (win_total)
  );

  bim_classify #(.ACC_W(ACC_W)) u_classify (
    .win_total    (win_total),
    .cfg_hi_level (cfg_hi_level),
    .cfg_lo_level (cfg_lo_level),
    .win_class    (win_class)
  );

  bim_trigger #(.MCNT_W(MCNT_W), .HOLD_W(HOLD_W)) u_trigger (
    .clk            (clk),
    .rst_n          (rst_n),
    .win_end        (win_end),
    .win_class      (win_class),
    .cfg_mid_needed (cfg_mid_needed),
    .cfg_holdoff    (cfg_holdoff_cycles),
    .irq            (irq)
  );
endmodule

// File: rtl/bim_checker.sv
module bim_checker #(
  parameter int ACC_W  = 24,
  parameter int HOLD_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              win_end,
  input logic [ACC_W-1:0]  win_total,
  input logic [ACC_W-1:0]  cfg_hi_level,
  input logic [ACC_W-1:0]  cfg_lo_level,
  input logic [HOLD_W-1:0] cfg_holdoff
);
  logic [HOLD_W:0] since_q;
  logic            seen_q;
  logic            hold_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (irq) begin
      since_q <= (HOLD_W+1)'(1);
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + (HOLD_W+1)'(1);
    end
  end

  assign hold_free = !seen_q || (since_q >= {1'b0, cfg_holdoff});

  AST_IRQ_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(win_end)); // R1

  AST_HIGH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (win_total >= cfg_hi_level) && hold_free) |=> irq); // R2

  AST_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (win_total < cfg_lo_level) && (win_total < cfg_hi_level)) |=> !irq); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5

  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && seen_q) |-> (since_q > {1'b0, cfg_holdoff})); // R6
endmodule

bind burst_irq_monitor bim_checker #(.ACC_W(ACC_W), .HOLD_W(HOLD_W)) u_bim_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .win_end      (win_end),
  .win_total    (win_total),
  .cfg_hi_level (cfg_hi_level),
  .cfg_lo_level (cfg_lo_level),
  .cfg_holdoff  (cfg_holdoff_cycles)
);

// File: tb/burst_irq_monitor_tb.sv
`timescale 1ns/1ps
module burst_irq_monitor_tb;
  localparam int BYTE_W = 6;
  localparam int ACC_W  = 8;
  localparam int MCNT_W = 2;
  localparam int WIN_W  = 4;
  localparam int HOLD_W = 6;
  localparam int ACC_MAX = (1 << ACC_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0;
  logic [BYTE_W-1:0] rx_bytes = '0;
  logic [ACC_W-1:0]  cfg_hi = '0;
  logic [ACC_W-1:0]  cfg_lo = '0;
  logic [MCNT_W-1:0] cfg_mid = '0;
  logic [WIN_W-1:0]  cfg_win = '0;
  logic [HOLD_W-1:0] cfg_hold = '0;
  logic              irq;

  always #2 clk = ~clk;

  burst_irq_monitor #(
    .BYTE_W(BYTE_W), .ACC_W(ACC_W), .MCNT_W(MCNT_W), .WIN_W(WIN_W), .HOLD_W(HOLD_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bytes(rx_bytes),
    .cfg_hi_level(cfg_hi), .cfg_lo_level(cfg_lo), .cfg_mid_needed(cfg_mid),
    .cfg_window_cycles(cfg_win), .cfg_holdoff_cycles(cfg_hold), .irq(irq)
  );

  int n_checks = 0;
  int n_errors = 0;
  int cyc;
  int m_acc, m_raw, m_mod, m_last;
  bit m_have;
  bit exp_irq;
  string exp_tag;
  bit irq_log [0:31];

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic do_reset(input int l, input int h, input int mc, input int hi, input int lo);
    rst_n = 1'b0;
    rx_valid = 1'b0;
    rx_bytes = '0;
    cfg_win = WIN_W'(l);
    cfg_hold = HOLD_W'(h);
    cfg_mid = MCNT_W'(mc);
    cfg_hi = ACC_W'(hi);
    cfg_lo = ACC_W'(lo);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8", int'(irq), 0);
    end
    rst_n = 1'b1;
    cyc = 0;
    m_acc = 0; m_raw = 0; m_mod = 0; m_last = 0; m_have = 1'b0;
    check("R8", int'(irq), 0);
  endtask

  // one cycle of stimulus plus the requirement-level window model
  task automatic run_cycle(input int b);
    int eff_l;
    int need;
    bit bnd;
    bit hold;
    eff_l = (int'(cfg_win) < 2) ? 2 : int'(cfg_win);
    need = (int'(cfg_mid) == 0) ? 1 : int'(cfg_mid);
    bnd = ((cyc % eff_l) == eff_l - 1);
    rx_valid = (b != 0);
    rx_bytes = (b != 0) ? BYTE_W'(b) : '1;  // ignored bytes when strobe is low
    exp_irq = 1'b0;
    exp_tag = "R5";
    if (bnd) begin
      hold = m_have && (cyc < m_last + int'(cfg_hold));
      if (m_acc >= int'(cfg_hi)) begin
        if (!hold) begin
          exp_irq = 1'b1;
          m_mod = 0;
          exp_tag = (m_raw > ACC_MAX) ? "R9" : "R2";
        end else begin
          exp_tag = "R6";
        end
      end else if (m_acc >= int'(cfg_lo)) begin
        exp_tag = hold ? "R7" : "R3";
        if (m_mod + 1 >= need) begin
          m_mod = 0;
          exp_irq = !hold;
        end else begin
          m_mod = m_mod + 1;
        end
      end else begin
        exp_tag = (m_raw > ACC_MAX) ? "R9" : "R4";
      end
      if (exp_irq) begin
        m_last = cyc + 1;
        m_have = 1'b1;
      end
      m_acc = b;
      m_raw = b;
    end else begin
      m_raw = m_raw + b;
      m_acc = (m_acc + b > ACC_MAX) ? ACC_MAX : m_acc + b;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check(exp_tag, int'(irq), int'(exp_irq));
  endtask

  function automatic int sweep_byte(input int c, input int eff_l, input int seed);
    int w;
    int mode;
    w = (c + 1) / eff_l;
    mode = (w * w + 3 * w + seed) % 4;
    case (mode)
      0: return 0;
      1: return (c * 7) % 6;
      2: return 20 + (c % 3);
      default: return 63;
    endcase
  endfunction

  initial begin
    int lens [3] = '{2, 5, 8};
    int holds [3] = '{0, 7, 30};
    int mids [3] = '{0, 1, 3};
    int seed;
    // directed: carried closing-cycle byte, equality at both levels
    do_reset(4, 3, 2, 40, 20);
    for (int c = 0; c < 16; c++) begin
      int b;
      b = (c == 1) ? 40 : (c == 3) ? 39 : (c == 7) ? 20 : 0;
      run_cycle(b);
      irq_log[cyc] = irq;
    end
    check("R1", int'(irq_log[4]), 1);
    check("R1", int'(irq_log[8]), 0);
    check("R1", int'(irq_log[12]), 1);

    // sweep over window, hold-off and tally settings
    seed = 0;
    foreach (lens[i]) begin
      foreach (holds[j]) begin
        foreach (mids[k]) begin
          int eff_l;
          eff_l = (lens[i] < 2) ? 2 : lens[i];
          do_reset(lens[i], holds[j], mids[k], 200, 60);
          for (int c = 0; c < 24 * eff_l; c++) begin
            run_cycle(sweep_byte(cyc, eff_l, seed));
          end
          seed++;
        end
      end
    end

    // window length below two behaves as two
    do_reset(1, 0, 1, 40, 20);
    for (int c = 0; c < 12; c++) begin
      run_cycle((c % 4 == 0) ? 45 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule